// File: doc/BRIEF.md
# PCM Highway Time-Slot Assigner

This block places eight voice channels onto a frame-synchronised serial PCM bus. The bus has two transmit lines and two receive lines. A frame holds 128 slots of 8 bit clocks each, and the block's clock is the bit clock. Each channel owns one transmit slot and one receive slot, and each direction has its own line-select bit. In its transmit slot a channel's 8-bit sample is shifted out MSB first on the line it selects. In its receive slot the chosen receive line is shifted in, and the completed byte is presented with a one-cycle valid pulse.

A byte-wide command port sets each channel's assignments and reads them back. A frame-sync pulse starts slot 0. The slot counter then runs freely and wraps after slot 127 until the next pulse. Two channels may share a transmit slot on the same line. In that case the lower-numbered channel takes the line.

Top module: `pcm_slot_assigner`

## Requirements
- R1: After reset, channel n (0 to 7) has transmit slot n and receive slot n, with highway bit 0 in both directions. A read of either assignment returns the byte n.
- R2: Command byte bit 7 selects read (1) or write (0), and bits 6:0 give the address: 0x08 is the transmit assignment and 0x09 is the receive assignment of the channel on `cfg_chan`. In the data byte, bit 7 is the highway select and bits 6:0 are the slot. A read result appears on `cfg_rdata` in the cycle after the command. Writes to any other address change nothing, and reads of any other address return 0. A read never modifies an assignment.
- R3: `frame_sync` sampled high at a clock edge makes the following cycle bit 0 of slot 0. Each slot is 8 cycles long. After bit 7 of slot 127 the count wraps to slot 0 bit 0 without a new frame sync, and a frame sync in mid-frame restarts it at slot 0.
- R4: From reset until the first frame sync, both transmit enables are low and no receive valid is raised.
- R5: During the 8 cycles of a channel's transmit slot, the line chosen by its highway bit (0 selects line 0, 1 selects line 1) has its enable high. In cycle b of the slot (b = 0 to 7), that line carries bit 7-b of the channel's sample.
- R6: In any cycle where no channel owns a transmit line, that line's enable is low and its data output is 0.
- R7: When several channels hold the same transmit slot on the same line, the lowest-numbered channel drives it.
- R8: A channel shifts in its chosen receive line (0 selects line 0, 1 selects line 1) MSB first over its 8 slot cycles. In the cycle after the slot's eighth bit, its `rx_bytes` byte holds the received value and its `rx_valid` bit is high for exactly one cycle. Several channels on the same slot capture independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame start pulse; the next cycle is slot 0 bit 0 |
| cfg_valid | input | 1 | Command strobe |
| cfg_cmd | input | 8 | Bit 7 read/write, bits 6:0 address |
| cfg_chan | input | 3 | Channel addressed by the command |
| cfg_wdata | input | 8 | Write data: bit 7 highway, bits 6:0 slot |
| cfg_rdata | output | 8 | Read data, valid the cycle after a read |
| tx_samples | input | 64 | Transmit samples, channel n at bits 8n+7:8n |
| dx_data | output | 2 | Transmit line data |
| dx_oe | output | 2 | Transmit line output enables |
| dr_data | input | 2 | Receive line data |
| rx_bytes | output | 64 | Received bytes, channel n at bits 8n+7:8n |
| rx_valid | output | 8 | One-cycle capture pulse per channel |

## Verification
A write takes effect from the next cycle. A read result is due one cycle after the command, so the bench samples it at the following falling edge. The transmit outputs are decoded combinationally from the registered frame position, so the bench sees the line for position p at the falling edge of the cycle that follows the edge at which the counter reached p; the first such cycle comes right after the frame-sync edge. A receive byte and its valid pulse are due one cycle after the eighth bit, so the bench drives each receive bit at a falling edge and, at the falling edge one cycle after a slot ends, checks the capture against the slot that just closed. Each frame run walks 1025 positions, so the wrap into slot 0 and captures in slot 127 fall inside the run.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;

    localparam int CH_N     = 8;
    localparam int CH_W     = $clog2(CH_N);
    localparam int SLOT_W   = 7;
    localparam int BYTE_W   = 8;
    localparam int BITPOS_W = $clog2(BYTE_W);
    localparam int LINE_N   = 2;

    localparam logic [6:0] ADDR_TX_ASSIGN = 7'h08;
    localparam logic [6:0] ADDR_RX_ASSIGN = 7'h09;

    typedef enum logic {
        CMD_WRITE = 1'b0,
        CMD_READ  = 1'b1
    } cmd_dir_e;

    typedef struct packed {
        cmd_dir_e   dir;
        logic [6:0] addr;
    } cmd_t;

    // One channel's slot assignment in one direction; also the register byte.
    typedef struct packed {
        logic              hwy;
        logic [SLOT_W-1:0] slot;
    } assign_t;

    typedef struct packed {
        logic                synced;
        logic [SLOT_W-1:0]   slot;
        logic [BITPOS_W-1:0] bitpos;
    } frame_pos_t;

    function automatic assign_t default_assign(input int ch);
        assign_t a;
        a.hwy  = 1'b0;
        a.slot = SLOT_W'(ch);
        return a;
    endfunction

    function automatic logic at_last_bit(input frame_pos_t p);
        return p.bitpos == BITPOS_W'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/pcm_tsa_timer.sv
module pcm_tsa_timer
    import pcm_tsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_sync,
    output frame_pos_t pos
);

    frame_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (frame_sync) begin
            pos_q.synced <= 1'b1;
            pos_q.slot   <= '0;
            pos_q.bitpos <= '0;
        end else if (pos_q.synced) begin
            pos_q.bitpos <= pos_q.bitpos + 1'b1;
            if (at_last_bit(pos_q)) begin
                pos_q.slot <= pos_q.slot + 1'b1;
            end
        end
    end

    assign pos = pos_q;

    // R3: the slot only advances on the last bit of a slot
    assert_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_q.synced && !frame_sync && !at_last_bit(pos_q)) |=> $stable(pos_q.slot));

    // R3: after the last bit the next slot begins at bit 0
    assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_q.synced && !frame_sync && at_last_bit(pos_q))
            |=> (pos_q.bitpos == '0 && pos_q.slot == $past(pos_q.slot) + 1'b1));

endmodule

// File: rtl/pcm_tsa_cfg.sv
module pcm_tsa_cfg
    import pcm_tsa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_valid,
    input  logic [BYTE_W-1:0]      cfg_cmd,
    input  logic [CH_W-1:0]        cfg_chan,
    input  logic [BYTE_W-1:0]      cfg_wdata,
    output logic [BYTE_W-1:0]      cfg_rdata,
    output assign_t [CH_N-1:0]     tx_asg,
    output assign_t [CH_N-1:0]     rx_asg
);

    cmd_t              cmd;
    logic              wr_tx, wr_rx, rd_any;
    assign_t [CH_N-1:0] tx_q, rx_q;
    logic [BYTE_W-1:0] rd_val;

    assign cmd = cmd_t'(cfg_cmd);

    always_comb begin
        wr_tx  = cfg_valid && cmd.dir == CMD_WRITE && cmd.addr == ADDR_TX_ASSIGN;
        wr_rx  = cfg_valid && cmd.dir == CMD_WRITE && cmd.addr == ADDR_RX_ASSIGN;
        rd_any = cfg_valid && cmd.dir == CMD_READ;
        unique case (cmd.addr)
            ADDR_TX_ASSIGN: rd_val = tx_q[cfg_chan];
            ADDR_RX_ASSIGN: rd_val = rx_q[cfg_chan];
            default:        rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < CH_N; ch++) begin
                tx_q[ch] <= default_assign(ch);
                rx_q[ch] <= default_assign(ch);
            end
            cfg_rdata <= '0;
        end else begin
            if (wr_tx) begin
                tx_q[cfg_chan] <= assign_t'(cfg_wdata);
            end
            if (wr_rx) begin
                rx_q[cfg_chan] <= assign_t'(cfg_wdata);
            end
            if (rd_any) begin
                cfg_rdata <= rd_val;
            end
        end
    end

    assign tx_asg = tx_q;
    assign rx_asg = rx_q;

    // R2: a read command leaves both assignment tables untouched
    assert_read_keeps_tables_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cmd.dir == CMD_READ) |=> ($stable(tx_q) && $stable(rx_q)));

    // R2: a command to any other address changes nothing
    assert_foreign_addr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cmd.addr != ADDR_TX_ASSIGN && cmd.addr != ADDR_RX_ASSIGN)
            |=> ($stable(tx_q) && $stable(rx_q)));

endmodule

// File: rtl/pcm_tsa_tx.sv
module pcm_tsa_tx
    import pcm_tsa_pkg::*;
(
    input  frame_pos_t                 pos,
    input  assign_t [CH_N-1:0]         tx_asg,
    input  logic [CH_N*BYTE_W-1:0]     tx_samples,
    output logic [LINE_N-1:0]          dx_data,
    output logic [LINE_N-1:0]          dx_oe
);

    logic [BITPOS_W-1:0] msb_idx;
    assign msb_idx = BITPOS_W'(BYTE_W - 1) - pos.bitpos;

    for (genvar ln = 0; ln < LINE_N; ln++) begin : g_line
        logic              hit;
        logic [CH_W-1:0]   win;
        logic [BYTE_W-1:0] win_byte;

        // Scan from the top so the lowest matching channel is kept last.
        always_comb begin
            hit = 1'b0;
            win = '0;
            for (int ch = CH_N - 1; ch >= 0; ch--) begin
                if (pos.synced && tx_asg[ch].slot == pos.slot
                        && tx_asg[ch].hwy == 1'(ln)) begin
                    hit = 1'b1;
                    win = CH_W'(ch);
                end
            end
        end

        assign win_byte   = tx_samples[win*BYTE_W +: BYTE_W];
        assign dx_oe[ln]  = hit;
        assign dx_data[ln] = hit & win_byte[msb_idx];

        // R4: no line is driven before the frame position is synchronised
        always_comb begin
            assert_no_drive_unsynced_R4: assert (pos.synced || !hit);
        end
    end

endmodule

// File: rtl/pcm_tsa_rx.sv
module pcm_tsa_rx
    import pcm_tsa_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  frame_pos_t                 pos,
    input  assign_t [CH_N-1:0]         rx_asg,
    input  logic [LINE_N-1:0]          dr_line,
    output logic [CH_N*BYTE_W-1:0]     rx_bytes,
    output logic [CH_N-1:0]            rx_valid
);

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
        logic [BYTE_W-1:0] shf, hold;
        logic              vld, mine, bit_in;

        assign mine   = pos.synced && rx_asg[ch].slot == pos.slot;
        assign bit_in = dr_line[rx_asg[ch].hwy];

        always_ff @(posedge clk) begin
            if (rst) begin
                shf  <= '0;
                hold <= '0;
                vld  <= 1'b0;
            end else begin
                vld <= 1'b0;
                if (mine) begin
                    shf <= {shf[BYTE_W-2:0], bit_in};
                    if (at_last_bit(pos)) begin
                        hold <= {shf[BYTE_W-2:0], bit_in};
                        vld  <= 1'b1;
                    end
                end
            end
        end

        assign rx_bytes[ch*BYTE_W +: BYTE_W] = hold;
        assign rx_valid[ch]                  = vld;

        // R8: valid follows the eighth bit of a slot
        assert_valid_after_last_bit_R8: assert property (@(posedge clk) disable iff (rst)
            vld |-> ($past(pos.bitpos) == BITPOS_W'(BYTE_W - 1)));

        // R8: valid is a single-cycle pulse
        assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
            vld |=> !vld);
    end

endmodule

// File: rtl/pcm_slot_assigner.sv
module pcm_slot_assigner
    import pcm_tsa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_sync,
    input  logic                   cfg_valid,
    input  logic [BYTE_W-1:0]      cfg_cmd,
    input  logic [CH_W-1:0]        cfg_chan,
    input  logic [BYTE_W-1:0]      cfg_wdata,
    output logic [BYTE_W-1:0]      cfg_rdata,
    input  logic [CH_N*BYTE_W-1:0] tx_samples,
    output logic [LINE_N-1:0]      dx_data,
    output logic [LINE_N-1:0]      dx_oe,
    input  logic [LINE_N-1:0]      dr_data,
    output logic [CH_N*BYTE_W-1:0] rx_bytes,
    output logic [CH_N-1:0]        rx_valid
);

    frame_pos_t         pos;
    assign_t [CH_N-1:0] tx_asg;
    assign_t [CH_N-1:0] rx_asg;

    pcm_tsa_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pos        (pos)
    );

    pcm_tsa_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .cfg_cmd   (cfg_cmd),
        .cfg_chan  (cfg_chan),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tx_asg    (tx_asg),
        .rx_asg    (rx_asg)
    );

    pcm_tsa_tx u_tx (
        .pos        (pos),
        .tx_asg     (tx_asg),
        .tx_samples (tx_samples),
        .dx_data    (dx_data),
        .dx_oe      (dx_oe)
    );

    pcm_tsa_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .rx_asg   (rx_asg),
        .dr_line  (dr_data),
        .rx_bytes (rx_bytes),
        .rx_valid (rx_valid)
    );

    // R5: line ownership holds for the whole slot while the tables are unchanged
    assert_owner_steady_in_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (pos.synced && !frame_sync && !at_last_bit(pos) && !cfg_valid)
            |=> $stable(dx_oe));

    // R4: nothing is captured before the first frame sync
    assert_no_capture_unsynced_R4: assert property (@(posedge clk) disable iff (rst)
        !pos.synced |=> (rx_valid == '0));

endmodule

// File: tb/tb_pcm_slot_assigner.sv
module tb_pcm_slot_assigner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_cmd = '0;
    logic [2:0]  cfg_chan = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [63:0] tx_samples = '0;
    logic [1:0]  dx_data, dx_oe;
    logic [1:0]  dr_data = '0;
    logic [63:0] rx_bytes;
    logic [7:0]  rx_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] m_tx [0:7];
    logic [7:0] m_rx [0:7];
    logic [7:0] samp [0:7];

    always #5 clk = ~clk;

    pcm_slot_assigner dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd), .cfg_chan(cfg_chan),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_samples(tx_samples), .dx_data(dx_data), .dx_oe(dx_oe),
        .dr_data(dr_data), .rx_bytes(rx_bytes), .rx_valid(rx_valid)
    );

    // {address, channel, write data, expected readback}
    localparam logic [31:0] VEC [0:9] = '{
        {8'h08, 8'd0, 8'h85, 8'h85},
        {8'h08, 8'd3, 8'h05, 8'h05},
        {8'h08, 8'd5, 8'h05, 8'h05},
        {8'h08, 8'd7, 8'h7F, 8'h7F},
        {8'h08, 8'd6, 8'h85, 8'h85},
        {8'h09, 8'd2, 8'h8A, 8'h8A},
        {8'h09, 8'd4, 8'h0A, 8'h0A},
        {8'h09, 8'd6, 8'h7F, 8'h7F},
        {8'h0C, 8'd1, 8'hAA, 8'h00},
        {8'h0A, 8'd1, 8'h55, 8'h00}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int ch = 0; ch < 8; ch++) begin
            m_tx[ch] = 8'(ch);
            m_rx[ch] = 8'(ch);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [2:0] ch, input logic [7:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_cmd = {1'b0, a}; cfg_chan = ch; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (a == 7'h08) m_tx[ch] = d;
        else if (a == 7'h09) m_rx[ch] = d;
    endtask

    task automatic cfg_read(input logic [6:0] a, input logic [2:0] ch, output logic [7:0] q);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_cmd = {1'b1, a}; cfg_chan = ch; cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_valid = 1'b0;
        q = cfg_rdata;
    endtask

    task automatic set_samples(input logic [7:0] seed);
        for (int ch = 0; ch < 8; ch++) begin
            samp[ch] = seed ^ 8'(ch * 29 + 3);
            tx_samples[ch*8 +: 8] = samp[ch];
        end
    endtask

    function automatic logic [7:0] pat(input int ln, input int s);
        return 8'((s * 37 + ln * 91 + 5) & 255);
    endfunction

    // {oe[1:0], data[1:0]} expected at frame position p
    function automatic logic [3:0] exp_dx(input int p);
        int s;
        int b;
        logic [1:0] oe;
        logic [1:0] d;
        s = (p / 8) % 128;
        b = p % 8;
        oe = '0;
        d = '0;
        for (int ln = 0; ln < 2; ln++) begin
            for (int ch = 0; ch < 8; ch++) begin
                if (!oe[ln] && int'(m_tx[ch][6:0]) == s && int'(m_tx[ch][7]) == ln) begin
                    oe[ln] = 1'b1;
                    d[ln] = samp[ch][7 - b];
                end
            end
        end
        return {oe, d};
    endfunction

    task automatic run_frame();
        logic [3:0] e;
        logic [7:0] ev;
        @(negedge clk);
        frame_sync = 1'b1;
        dr_data = '0;
        for (int k = 0; k <= 1024; k++) begin
            @(negedge clk);
            frame_sync = 1'b0;
            e = exp_dx(k % 1024);
            if (e[3:2] == 2'b00)
                chk("R6", $sformatf("idle lines at pos %0d", k), {dx_oe, dx_data}, e);
            else if (((k / 8) % 128) == 5)
                chk("R7", $sformatf("shared slot at pos %0d", k), {dx_oe, dx_data}, e);
            else if (k == 0 || k == 1024)
                chk("R3", $sformatf("slot 0 start at pos %0d", k), {dx_oe, dx_data}, e);
            else
                chk("R5", $sformatf("tx lines at pos %0d", k), {dx_oe, dx_data}, e);
            if (k > 0) begin
                ev = '0;
                if (((k - 1) % 8) == 7) begin
                    for (int ch = 0; ch < 8; ch++) begin
                        if (int'(m_rx[ch][6:0]) == (k - 1) / 8) begin
                            ev[ch] = 1'b1;
                            chk("R8", $sformatf("rx byte ch%0d slot %0d", ch, (k - 1) / 8),
                                rx_bytes[ch*8 +: 8], pat(int'(m_rx[ch][7]), (k - 1) / 8));
                        end
                    end
                end
                chk("R8", $sformatf("rx valid after pos %0d", k - 1), rx_valid, ev);
            end
            if (k < 1024) begin
                for (int ln = 0; ln < 2; ln++) begin
                    logic [7:0] pb;
                    pb = pat(ln, k / 8);
                    dr_data[ln] = pb[7 - (k % 8)];
                end
            end else begin
                dr_data = '0;
            end
        end
    endtask

    initial begin
        logic [7:0] q;
        set_samples(8'hA5);
        do_reset();

        // R4: idle after reset, even with activity on the receive lines
        dr_data = 2'b11;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk("R4", "tx enable before sync", dx_oe, 2'b00);
            chk("R4", "rx valid before sync", rx_valid, 8'h00);
        end
        dr_data = 2'b00;

        // R1: default assignments
        for (int ch = 0; ch < 8; ch++) begin
            cfg_read(7'h08, 3'(ch), q);
            chk("R1", $sformatf("tx default ch%0d", ch), q, 8'(ch));
            cfg_read(7'h09, 3'(ch), q);
            chk("R1", $sformatf("rx default ch%0d", ch), q, 8'(ch));
        end
        chk("R4", "tx enable after reads, still unsynced", dx_oe, 2'b00);

        // R1 R5 R8: one frame with default assignments
        run_frame();

        // R2: table of writes with readback
        for (int i = 0; i < 10; i++) begin
            cfg_write(VEC[i][30:24], VEC[i][18:16], VEC[i][15:8]);
            cfg_read(VEC[i][30:24], VEC[i][18:16], q);
            chk("R2", $sformatf("readback vector %0d", i), q, VEC[i][7:0]);
        end
        cfg_read(7'h08, 3'd1, q);
        chk("R2", "tx ch1 untouched by foreign writes", q, 8'h01);
        cfg_read(7'h09, 3'd1, q);
        chk("R2", "rx ch1 untouched by foreign writes", q, 8'h01);
        cfg_read(7'h08, 3'd0, q);
        chk("R2", "read did not write 0xFF", q, 8'h85);

        // R3 R5 R6 R7 R8: frame sync arrives mid-frame, new map and samples
        set_samples(8'h3C);
        run_frame();

        // R1 R4: reset during operation restores defaults and idles the lines
        do_reset();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R4", "tx enable after mid-run reset", dx_oe, 2'b00);
        end
        cfg_read(7'h08, 3'd0, q);
        chk("R1", "tx ch0 default after reset", q, 8'h00);
        cfg_read(7'h09, 3'd6, q);
        chk("R1", "rx ch6 default after reset", q, 8'h06);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule